// File: doc/BRIEF.md
# Windowed Priority Activity Detector

This block decides whether a co-located radio is carrying priority traffic by watching that radio's asynchronous priority line. The line is first synchronized. On every enabled sample strobe the block counts whether the line reads high. Once a programmable number of enabled clock cycles has gone by, the next strobe closes the observation window. The block then compares the number of high samples with a programmable threshold and registers the verdict.

The verdict stays fixed for the whole of the following window. It is a windowed density measure, not an edge or level detector. Each evaluation also raises a one-cycle update pulse, so a consumer knows that a fresh verdict is available. A resume command restarts observation from a clean state. An enable input freezes the observation when it is low.

Top module: `prio_activity_detector`

## Requirements
- R1: The priority input passes through a two-flop synchronizer. A change on `prio_async` that is set up before clock edge X is seen by a strobe at edge X+2 or later. Strobes at edges X and X+1 still see the old value.
- R2: On a clock edge where `enable` and `sample_stb` are both 1, the synchronized input is sampled. If it reads 1, the high count increases by one.
- R3: A window timer counts enabled clock edges from 0, starting at the edge where a window begins. A strobe closes the window only when the timer value before that edge is at least `window_len`. With the timer restarted at edge S, the first edge that can close the window is S+`window_len`+1. At the closing edge, both the count and the timer restart from zero, and a new window begins.
- R4: At the closing edge, `detected` becomes 1 if the high count, including the sample taken at that edge, is greater than or equal to `count_thresh`. Otherwise it becomes 0. A threshold of 0 always gives 1.
- R5: `update_pulse` is 1 for exactly the one cycle that follows each closing edge. Apart from closing edges and resume, `detected` keeps its value across the entire next window.
- R6: The high count saturates at its all-ones value (255 for the default 8-bit count) and never wraps.
- R7: When `resume` is 1 at a clock edge, the count, the timer and `detected` are all cleared, and no update pulse is raised. Resume takes priority over `enable` and `sample_stb`.
- R8: While `enable` is 0, strobes are ignored, the count and timer hold, and `detected` keeps its value. The synchronizer keeps running.
- R9: After reset, `detected` and `update_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Observation enable; low freezes count and timer |
| resume | input | 1 | Clears count, timer and verdict |
| sample_stb | input | 1 | Sample strobe |
| prio_async | input | 1 | Asynchronous priority line from the other radio |
| window_len | input | TIMER_W (16) | Minimum window length in enabled cycles |
| count_thresh | input | COUNT_W (8) | High-sample count needed for a positive verdict |
| detected | output | 1 | Registered verdict of the last closed window |
| update_pulse | output | 1 | One-cycle pulse after each window evaluation |

## Verification
`detected` and `update_pulse` change on the same edge as the closing strobe, so they can be read one time unit after that edge. A level change on the priority line reaches the sampler two edges later than the edge before which it was set up. The bench drives all inputs one time unit after a rising edge and reads the outputs at the same point after the next edge. It counts edges from each resume, and from these counts it predicts the exact closing edge as the later of `window_len`+1 and the first low-phase strobe. It then checks that no pulse appears before that edge, that a pulse appears on it, and that no pulse appears after it.

// File: rtl/prio_det_pkg.sv
package prio_det_pkg;
   localparam int DEF_TIMER_W     = 16;
   localparam int DEF_COUNT_W     = 8;
   localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/prio_det_sync.sv
module prio_det_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("prio_det_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/prio_det_timer.sv
module prio_det_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         restart,
   output logic [W-1:0] elapsed
);
   generate
      if (W < 1) begin : g_bad_width
         $error("prio_det_timer: W must be positive");
      end
   endgenerate

   localparam logic [W-1:0] MAXV = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      elapsed <= '0;
      else if (restart)                elapsed <= '0;
      else if (en && elapsed != MAXV)  elapsed <= elapsed + 1'b1;
   end

   AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !restart) |=> $stable(elapsed)); // R8
endmodule

// File: rtl/prio_det_counter.sv
module prio_det_counter #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clear,
   output logic [W-1:0] count_inc
);
   generate
      if (W < 1) begin : g_bad_width
         $error("prio_det_counter: W must be positive");
      end
   endgenerate

   localparam logic [W-1:0] MAXV = '1;

   logic [W-1:0] count;

   generate
      if (SATURATE) begin : g_sat
         assign count_inc = (inc && count != MAXV) ? count + 1'b1 : count;

         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (count == MAXV && inc && !clear) |=> (count == MAXV)); // R6
      end else begin : g_wrap
         assign count_inc = inc ? count + 1'b1 : count;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clear) count <= '0;
      else            count <= count_inc;
   end

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0)); // R3
endmodule

// File: rtl/prio_activity_detector.sv
module prio_activity_detector
   import prio_det_pkg::*;
#(
   parameter int TIMER_W     = DEF_TIMER_W,
   parameter int COUNT_W     = DEF_COUNT_W,
   parameter int SYNC_STAGES = DEF_SYNC_STAGES,
   parameter bit SATURATE    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               resume,
   input  logic               sample_stb,
   input  logic               prio_async,
   input  logic [TIMER_W-1:0] window_len,
   input  logic [COUNT_W-1:0] count_thresh,
   output logic               detected,
   output logic               update_pulse
);
   logic               prio_s;
   logic [TIMER_W-1:0] elapsed;
   logic [COUNT_W-1:0] count_inc;
   logic               take;
   logic               close_win;
   logic               restart;

   prio_det_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (prio_async),
      .dout (prio_s)
   );

   assign take      = enable && sample_stb && !resume;
   assign close_win = take && (elapsed >= window_len);
   assign restart   = resume || close_win;

   prio_det_timer #(.W(TIMER_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (enable),
      .restart(restart),
      .elapsed(elapsed)
   );

   prio_det_counter #(.W(COUNT_W), .SATURATE(SATURATE)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (take && prio_s),
      .clear    (restart),
      .count_inc(count_inc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         detected     <= 1'b0;
         update_pulse <= 1'b0;
      end else if (resume) begin
         detected     <= 1'b0;
         update_pulse <= 1'b0;
      end else begin
         update_pulse <= close_win;
         if (close_win) detected <= (count_inc >= count_thresh);
      end
   end

   AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      resume |=> (!detected && !update_pulse)); // R7

   AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !update_pulse |-> ($stable(detected) || $past(resume))); // R5

   AST_PULSE_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      update_pulse |-> $past(sample_stb && enable)); // R3
endmodule

// File: tb/prio_activity_detector_tb.sv
module prio_activity_detector_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TW = 16;
   localparam int CW = 8;
   localparam int NROWS = 7;

   // fields: [40:25] window_len, [24:17] threshold, [16:1] high strobes, [0] expected verdict
   localparam logic [40:0] ROWS [NROWS] = '{
      {16'd20,  8'd5,   16'd5,   1'b1},  // threshold met exactly
      {16'd20,  8'd5,   16'd4,   1'b0},  // one below threshold
      {16'd10,  8'd1,   16'd0,   1'b0},  // no highs
      {16'd0,   8'd1,   16'd0,   1'b0},  // zero length window
      {16'd400, 8'd255, 16'd300, 1'b1},  // R6 saturation: a wrap would give 44
      {16'd8,   8'd0,   16'd0,   1'b1},  // zero threshold
      {16'd30,  8'd3,   16'd10,  1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic resume = 1'b0;
   logic sample_stb = 1'b0;
   logic prio_async = 1'b0;
   logic [TW-1:0] window_len = '0;
   logic [CW-1:0] count_thresh = '0;
   logic detected;
   logic update_pulse;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_activity_detector #(.TIMER_W(TW), .COUNT_W(CW)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .resume      (resume),
      .sample_stb  (sample_stb),
      .prio_async  (prio_async),
      .window_len  (window_len),
      .count_thresh(count_thresh),
      .detected    (detected),
      .update_pulse(update_pulse)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // One strobe-or-idle edge at index idx; tallies pulses off the expected edge
   task automatic step(input logic stb, input int idx, input int e_edge,
                       inout int early, inout int seen);
      sample_stb = stb;
      tick();
      sample_stb = 1'b0;
      if (update_pulse && idx != e_edge) early++;
      if (update_pulse && idx == e_edge) seen = 1;
   endtask

   task automatic run_window(input int len, input int thr, input int h, input int exp_det,
                             input string tag);
      int e_edge, idx, early, seen;
      window_len   = len[TW-1:0];
      count_thresh = thr[CW-1:0];
      enable       = 1'b1;
      resume       = 1'b1;
      tick();
      resume     = 1'b0;
      prio_async = 1'b1;
      e_edge = (len + 1 > h + 7) ? len + 1 : h + 7;
      idx = 0; early = 0; seen = 0;
      for (int k = 0; k < 3; k++) begin idx++; step(1'b0, idx, e_edge, early, seen); end
      for (int k = 0; k < h; k++) begin idx++; step(1'b1, idx, e_edge, early, seen); end
      prio_async = 1'b0;
      for (int k = 0; k < 3; k++) begin idx++; step(1'b0, idx, e_edge, early, seen); end
      while (idx < e_edge) begin idx++; step(1'b1, idx, e_edge, early, seen); end
      check("R3", {tag, " pulses before window end"}, early, 0);
      check("R3", {tag, " pulse on closing edge"}, seen, 1);
      check(tag, "verdict (R4)", int'(detected), exp_det);
      tick();
      check("R5", {tag, " pulse lasts one cycle"}, int'(update_pulse), 0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL all watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      // R9 reset state
      repeat (3) tick();
      check("R9", "detected in reset", int'(detected), 0);
      check("R9", "pulse in reset", int'(update_pulse), 0);
      rst_n = 1'b1;
      tick();
      check("R9", "detected after reset", int'(detected), 0);

      // Table of windows: R2 counting, R3 timing, R4 verdict, R6 saturation
      for (int r = 0; r < NROWS; r++) begin
         string tag;
         tag = (r == 4) ? "R6" : "R2/R4";
         run_window(int'(ROWS[r][40:25]), int'(ROWS[r][24:17]), int'(ROWS[r][16:1]),
                    int'(ROWS[r][0]), tag);
      end

      // R5: verdict held through the next window, then replaced
      run_window(10, 2, 4, 1, "R5");
      begin
         int bad_hold;
         bad_hold = 0;
         // one idle enabled edge already passed (k=1); strobes on k=2..11
         for (int k = 2; k <= 11; k++) begin
            sample_stb = 1'b1;
            tick();
            sample_stb = 1'b0;
            if (k < 11 && (update_pulse || !detected)) bad_hold++;
         end
         check("R5", "verdict held during next window", bad_hold, 0);
         check("R5", "second window pulse", int'(update_pulse), 1);
         check("R5", "second window verdict", int'(detected), 0);
      end

      // R1: synchronizer latency with a zero-length window and threshold 1
      window_len = '0; count_thresh = 8'd1; enable = 1'b1;
      prio_async = 1'b0;
      resume = 1'b1; tick(); resume = 1'b0;
      repeat (3) tick();
      prio_async = 1'b1;
      sample_stb = 1'b1; tick();
      check("R1", "strobe one edge after change", int'(detected), 0);
      tick();
      check("R1", "strobe two edges after change", int'(detected), 0);
      tick();
      check("R1", "strobe three edges after change", int'(detected), 1);
      sample_stb = 1'b0;

      // R7: resume beats a simultaneous strobe
      resume = 1'b1; sample_stb = 1'b1; tick();
      resume = 1'b0; sample_stb = 1'b0;
      check("R7", "resume clears verdict", int'(detected), 0);
      check("R7", "resume gives no pulse", int'(update_pulse), 0);

      // R8: enable low freezes count and timer
      window_len = 16'd5; count_thresh = 8'd1;
      enable = 1'b0;
      resume = 1'b1; tick(); resume = 1'b0;
      prio_async = 1'b1;
      repeat (3) tick();
      begin
         int stray;
         stray = 0;
         for (int k = 0; k < 20; k++) begin
            sample_stb = 1'b1; tick(); sample_stb = 1'b0;
            if (update_pulse || detected) stray++;
         end
         check("R8", "no evaluation while disabled", stray, 0);
      end
      enable = 1'b1;
      prio_async = 1'b0;
      begin
         int early, seen;
         early = 0; seen = 0;
         for (int m = 1; m <= 3; m++) step(1'b0, m, 6, early, seen);
         for (int m = 4; m <= 6; m++) step(1'b1, m, 6, early, seen);
         check("R8", "timer frozen: no early close", early, 0);
         check("R8", "close on sixth enabled edge", seen, 1);
         check("R8", "highs while disabled not counted", int'(detected), 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule